// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of devices and presents a single interrupt line, with the number of the chosen source, to a processor. Each source carries its own programmable priority, and a priority of zero masks it. When the processor takes an interrupt, the controller records the level now in service on an internal stack. It then sends a one-cycle acknowledge to the chosen device so the device can drop its request.

A mode input picks one of two service disciplines. In sequential mode, further interrupts stay disabled while any handler runs. Requests wait until the last handler has signalled completion. In nested mode, a request strictly above the level in service may preempt the running handler, and requests at or below that level are held. Each end-of-service pulse pops one level and restores the level below it. Any held request above the restored level is signalled in the same cycle, so it is taken before the resumed handler runs another instruction.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, cpu_irq is 0, dev_ack is all zero, svc_level is 0 and the service stack is empty.
- R2: A source whose 3-bit priority field (bits 3*i+2 down to 3*i of src_prio for source i) is 0 never causes cpu_irq, whatever its request line does.
- R3: Among requesting unmasked sources, cpu_vec gives the index of the one with the highest priority; on equal priority the lower index wins.
- R4: With nest_en = 1, cpu_irq is high in the same cycle exactly when the winning request's priority is strictly greater than svc_level (0 when idle).
- R5: With nest_en = 1, a request at a priority equal to or below svc_level is held: cpu_irq stays low and the request stays pending.
- R6: With nest_en = 0, cpu_irq stays low while any level is in service, and it rises once the stack is empty and an unmasked request is present.
- R7: A cpu_accept pulse while cpu_irq is high and cpu_eos is low pushes the winning priority, and svc_level shows it from the next cycle on.
- R8: The edge after an accepted interrupt, dev_ack carries a single-cycle pulse on the bit of the accepted source only; at all other times dev_ack is zero.
- R9: A cpu_eos pulse pops one level and restores the previous svc_level, or 0 when the stack empties; cpu_eos on an empty stack changes nothing.
- R10: In the cycle after a pop, a held request above the restored level drives cpu_irq high with its index on cpu_vec.
- R11: cpu_accept has no effect (no push, no acknowledge) when cpu_irq is low or cpu_eos is high in the same cycle.
- R12: With sources at priorities 2, 4 and 5 and nest_en = 1, the sequence low, preempting high, held middle, high completes, middle taken before low resumes, middle completes, and low resumes runs as described.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nest_en | input | 1 | 1 selects nested priority service, 0 selects sequential service |
| dev_req | input | NSRC | Level request line per device |
| src_prio | input | NSRC*PRIO_W | Priority per source, 0 masks the source |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_vec | output | $clog2(NSRC) | Index of the source being offered |
| cpu_accept | input | 1 | Processor takes the offered interrupt |
| cpu_eos | input | 1 | Processor signals end of the current handler |
| dev_ack | output | NSRC | One-cycle acknowledge to the accepted device |
| svc_level | output | PRIO_W | Priority currently in service, 0 when idle |

## Verification
The bench builds the block with its defaults: eight sources, 3-bit priorities and an eight-deep stack. Seven nonzero levels then reach a stack depth of seven through strict nesting, so random runs of nested preemption press close to a full stack. Tie-breaking among all eight indices and masking by a zero field both come within reach. Random phases switch between sequential and nested mode and reprogram the priorities, while directed cases cover the three-device preemption sequence, an end-of-service on an empty stack, and accepts given while no interrupt is offered.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic {
        SVC_SEQUENTIAL = 1'b0,
        SVC_NESTED     = 1'b1
    } svc_mode_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3
) (
    input  logic [NSRC-1:0]        req,
    input  logic [NSRC*PRIO_W-1:0] prio,
    output logic                   found,
    output logic [$clog2(NSRC)-1:0] win_idx,
    output logic [PRIO_W-1:0]      win_lvl
);
    localparam int IDX_W = $clog2(NSRC);

    logic [PRIO_W-1:0] lvl_s [NSRC+1];
    logic [IDX_W-1:0]  idx_s [NSRC+1];

    assign lvl_s[0] = '0;
    assign idx_s[0] = '0;

    // Chain of compare stages; strict greater-than keeps the lower index on ties
    // and a zero priority can never beat the initial zero level (masking).
    for (genvar i = 0; i < NSRC; i++) begin : g_stage
        logic [PRIO_W-1:0] p_i;
        logic              take;
        assign p_i  = prio[i*PRIO_W +: PRIO_W];
        assign take = req[i] && (p_i > lvl_s[i]);
        assign lvl_s[i+1] = take ? p_i : lvl_s[i];
        assign idx_s[i+1] = take ? IDX_W'(i) : idx_s[i];
    end

    assign win_lvl = lvl_s[NSRC];
    assign win_idx = idx_s[NSRC];
    assign found   = (lvl_s[NSRC] != '0);
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] push_lvl,
    output logic [LVL_W-1:0] top_lvl,
    output logic             empty,
    output logic             full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][LVL_W-1:0] slot;
        logic [CNT_W-1:0]            cnt;
    } stk_t;

    stk_t st_d, st_q;
    logic [CNT_W-1:0] top_pos;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == FULL_CNT);
    assign top_pos = st_q.cnt - 1'b1;
    assign top_lvl = empty ? '0 : st_q.slot[top_pos[IDX_W-1:0]];

    always_comb begin
        st_d = st_q;
        if (push && !full) begin
            st_d.slot[st_q.cnt[IDX_W-1:0]] = push_lvl;
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && !empty) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: the controller never pushes into a full stack
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9: a pop on an empty stack leaves it empty
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty);
    // R9: a pop from a non-empty stack lowers the count by one
    a_r9_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int DEPTH  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     nest_en,
    input  logic [NSRC-1:0]          dev_req,
    input  logic [NSRC*PRIO_W-1:0]   src_prio,
    output logic                     cpu_irq,
    output logic [$clog2(NSRC)-1:0]  cpu_vec,
    input  logic                     cpu_accept,
    input  logic                     cpu_eos,
    output logic [NSRC-1:0]          dev_ack,
    output logic [PRIO_W-1:0]        svc_level
);
    import irq_pkg::*;

    localparam int IDX_W = $clog2(NSRC);

    typedef struct packed {
        logic [NSRC-1:0] ack;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    svc_mode_e         mode;
    logic              found;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_lvl;
    logic [PRIO_W-1:0] top_lvl;
    logic              stk_empty;
    logic              stk_full;
    logic              offer;
    logic              take;
    logic              drop;

    assign mode = svc_mode_e'(nest_en);

    irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .req     (dev_req),
        .prio    (src_prio),
        .found   (found),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    irq_level_stack #(.DEPTH(DEPTH), .LVL_W(PRIO_W)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .pop      (drop),
        .push_lvl (win_lvl),
        .top_lvl  (top_lvl),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    always_comb begin
        ctl_d = '0;
        offer = 1'b0;
        if (found) begin
            if (mode == SVC_NESTED) offer = (win_lvl > top_lvl) && !stk_full;
            else                    offer = stk_empty;
        end
        drop = cpu_eos;
        take = cpu_accept && offer && !cpu_eos;
        if (take) ctl_d.ack = NSRC'(1) << win_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cpu_irq   = offer;
    assign cpu_vec   = win_idx;
    assign dev_ack   = ctl_q.ack;
    assign svc_level = top_lvl;

    // R8: at most one device is acknowledged at a time
    a_r8_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack));
    // R8: an acknowledge only follows an accepted interrupt
    a_r8_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_ack) |-> $past(take));
    // R7: after an accept the level in service is the accepted priority
    a_r7_push_level: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (svc_level == $past(win_lvl)));
    // R6: sequential mode offers nothing while a handler is in service
    a_r6_seq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_en && (svc_level != '0)) |-> !cpu_irq);
    // R4: nested mode only offers a request above the level in service
    a_r4_above_level: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_en && cpu_irq) |-> (win_lvl > svc_level));
endmodule

// File: tb/tb_nest_irq_ctrl.sv
`timescale 1ns/1ps
module tb_nest_irq_ctrl;
    localparam int NSRC = 8;
    localparam int PW   = 3;
    localparam int DEP  = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            nest_en;
    logic [NSRC-1:0] dev_req;
    logic [NSRC*PW-1:0] src_prio;
    logic            cpu_irq;
    logic [2:0]      cpu_vec;
    logic            cpu_accept;
    logic            cpu_eos;
    logic [NSRC-1:0] dev_ack;
    logic [PW-1:0]   svc_level;

    int n_chk = 0;
    int n_bad = 0;

    logic [PW-1:0]   m_stk [DEP];
    int              m_cnt;
    logic [NSRC-1:0] m_ack;

    always #5 clk = ~clk;

    nest_irq_ctrl #(.NSRC(NSRC), .PRIO_W(PW), .DEPTH(DEP)) dut (
        .clk(clk), .rst_n(rst_n), .nest_en(nest_en), .dev_req(dev_req),
        .src_prio(src_prio), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec),
        .cpu_accept(cpu_accept), .cpu_eos(cpu_eos), .dev_ack(dev_ack),
        .svc_level(svc_level)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_top();
        return (m_cnt == 0) ? 0 : int'(m_stk[m_cnt-1]);
    endfunction

    // Reference pick: highest priority, lowest index on a tie, zero masks.
    function automatic int m_best_lvl();
        int b = 0;
        for (int i = 0; i < NSRC; i++)
            if (dev_req[i] && int'(src_prio[i*PW +: PW]) > b) b = int'(src_prio[i*PW +: PW]);
        return b;
    endfunction

    function automatic int m_best_idx();
        int b = 0;
        int bi = 0;
        for (int i = 0; i < NSRC; i++)
            if (dev_req[i] && int'(src_prio[i*PW +: PW]) > b) begin
                b = int'(src_prio[i*PW +: PW]);
                bi = i;
            end
        return bi;
    endfunction

    function automatic logic m_irq();
        int b = m_best_lvl();
        if (b == 0) return 1'b0;
        if (nest_en) return (b > m_top()) && (m_cnt < DEP);
        return (m_cnt == 0);
    endfunction

    task automatic step();
        logic e_irq;
        @(negedge clk);
        e_irq = m_irq();
        chk(cpu_irq == e_irq, nest_en ? "R4/R5 irq nested" : "R6 irq sequential",
            int'(cpu_irq), int'(e_irq));
        if (e_irq) chk(int'(cpu_vec) == m_best_idx(), "R3 vector", int'(cpu_vec), m_best_idx());
        chk(int'(svc_level) == m_top(), "R7/R9 level", int'(svc_level), m_top());
        chk(dev_ack == m_ack, "R8 ack", int'(dev_ack), int'(m_ack));
        @(posedge clk);
        m_ack = '0;
        if (cpu_eos) begin
            if (m_cnt > 0) m_cnt--;
        end else if (cpu_accept && e_irq) begin
            m_stk[m_cnt] = PW'(m_best_lvl());
            m_cnt++;
            m_ack = NSRC'(1) << m_best_idx();
        end
        #1;
    endtask

    function automatic void set_prio(input int idx, input int p);
        src_prio[idx*PW +: PW] = PW'(p);
    endfunction

    initial begin
        #(200000 * 10);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        rst_n = 1'b0; nest_en = 1'b1; dev_req = '0; src_prio = '0;
        cpu_accept = 1'b0; cpu_eos = 1'b0;
        m_cnt = 0; m_ack = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cpu_irq == 1'b0, "R1 irq", int'(cpu_irq), 0);
        chk(dev_ack == '0, "R1 ack", int'(dev_ack), 0);
        chk(svc_level == '0, "R1 level", int'(svc_level), 0);
        @(posedge clk); #1;

        // R2: all masked, all requesting
        dev_req = '1; src_prio = '0; cpu_accept = 1'b1;
        #1 chk(cpu_irq == 1'b0, "R2 masked irq", int'(cpu_irq), 0);
        step();
        cpu_accept = 1'b0;
        step();
        chk(svc_level == '0, "R2/R11 no push", int'(svc_level), 0);

        // R3: tie between sources 3 and 5 at priority 6
        dev_req = 8'b0010_1000; set_prio(3, 6); set_prio(5, 6);
        #1 chk(cpu_vec == 3'd3, "R3 tie lower index", int'(cpu_vec), 3);
        // R11: accept together with eos is ignored
        cpu_accept = 1'b1; cpu_eos = 1'b1;
        step();
        cpu_accept = 1'b0; cpu_eos = 1'b0;
        step();
        chk(svc_level == '0 && dev_ack == '0, "R11 accept with eos", int'(svc_level), 0);
        // R9: eos on empty stack
        cpu_eos = 1'b1; step(); cpu_eos = 1'b0; step();
        chk(svc_level == '0, "R9 empty pop", int'(svc_level), 0);

        // R12: printer=0 (2), disk=1 (4), comm=2 (5)
        src_prio = '0; set_prio(0, 2); set_prio(1, 4); set_prio(2, 5);
        dev_req = 8'b001; cpu_accept = 1'b1;
        #1 chk(cpu_irq && cpu_vec == 3'd0, "R12 printer offered", int'(cpu_vec), 0);
        step();
        cpu_accept = 1'b0;
        chk(dev_ack == 8'b001, "R8/R12 printer ack", int'(dev_ack), 1);
        dev_req = '0; step();
        chk(svc_level == 3'd2, "R12 printer in service", int'(svc_level), 2);
        dev_req = 8'b100; cpu_accept = 1'b1;
        #1 chk(cpu_irq && cpu_vec == 3'd2, "R12 comm preempts", int'(cpu_vec), 2);
        step();
        cpu_accept = 1'b0; dev_req = '0; step();
        chk(svc_level == 3'd5, "R12 comm in service", int'(svc_level), 5);
        dev_req = 8'b010;
        #1 chk(cpu_irq == 1'b0, "R5/R12 disk held", int'(cpu_irq), 0);
        step();
        cpu_eos = 1'b1; step(); cpu_eos = 1'b0;
        #1 chk(cpu_irq && cpu_vec == 3'd1, "R10/R12 disk before printer", int'(cpu_vec), 1);
        chk(svc_level == 3'd2, "R9/R12 restored printer level", int'(svc_level), 2);
        cpu_accept = 1'b1; step(); cpu_accept = 1'b0; dev_req = '0; step();
        chk(svc_level == 3'd4, "R12 disk in service", int'(svc_level), 4);
        cpu_eos = 1'b1; step(); cpu_eos = 1'b0; step();
        chk(svc_level == 3'd2 && !cpu_irq, "R12 printer resumed", int'(svc_level), 2);
        cpu_eos = 1'b1; step(); cpu_eos = 1'b0; step();
        chk(svc_level == 3'd0, "R12 user resumed", int'(svc_level), 0);

        // R6: sequential mode holds a higher request until the stack empties
        nest_en = 1'b0; dev_req = 8'b001; cpu_accept = 1'b1; step();
        cpu_accept = 1'b0; dev_req = 8'b100;
        #1 chk(cpu_irq == 1'b0, "R6 held in sequential", int'(cpu_irq), 0);
        step();
        cpu_eos = 1'b1; step(); cpu_eos = 1'b0;
        #1 chk(cpu_irq == 1'b1, "R6 offered after eos", int'(cpu_irq), 1);
        step();

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            if (k % 250 == 0) begin
                for (int s = 0; s < NSRC; s++)
                    set_prio(s, ($urandom % 5 == 0) ? 0 : int'($urandom % 8));
            end
            if (k % 700 == 0) nest_en = $urandom % 2;
            dev_req    = NSRC'($urandom);
            cpu_accept = ($urandom % 3 != 0);
            cpu_eos    = ($urandom % 5 == 0);
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule